// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This unit belongs to the decode stage of an in-order five-stage pipeline. A value returned by a load reaches the pipeline only at the end of the memory stage. The instruction right behind the load therefore cannot get that value through forwarding from the execute stage. The unit watches for this case and holds the front of the pipeline for one cycle. During that cycle it drops the PC and instruction-register write enables and puts an empty slot into execute, while the load itself moves on to the memory stage.

The unit does not compare register numbers itself. It uses the operand select codes that the forwarding logic has already computed in decode. A select code of 1 on either operand means "take the value from the instruction now in execute". When that instruction is a load, the value does not exist yet. The unit also contains the execute-stage control register. On each edge this register loads either the decode control word or that word with its side-effect bits cleared. Because the register's memory-read bit is cleared during the stall, the stall drops by itself one cycle later. In that cycle the forwarding logic sees the load in the memory stage, produces code 2, and the dependent instruction goes ahead.

Top module: `ld_use_stall_unit`

## Requirements
- R1: When the execute-stage control word has its memory-read bit (bit 1) set and either operand select equals 1, `bubble` is 1 and both `pc_we` and `ir_we` are 0 in that same cycle.
- R2: When the execute-stage memory-read bit is 0, `bubble` is 0 and both write enables are 1, whatever the operand select values.
- R3: With a load in execute, operand select values 0, 2 and 3 on both operands cause no stall.
- R4: On an edge where `bubble` is 1, the execute control register takes the decode control word with bits 4:0 cleared (bit 0 register write, bit 1 memory read, bit 2 memory write, bit 3 branch, bit 4 jump).
- R5: On an edge where `bubble` is 0, the execute control register takes the decode control word unchanged.
- R6: A stall lasts exactly one cycle. The load has left execute in the cycle after a stall, so `bubble` is 0 in that cycle even if the operand selects still read 1.
- R7: While reset is asserted, the execute control word is 0, `ex_load` is 0, `bubble` is 0 and both write enables are 1.
- R8: During a bubble, control bits 7:5 (datapath selects with no side effects) pass into the execute control register unchanged.
- R9: `ex_load` always equals bit 1 of `ex_ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_ctrl | input | 8 | Control word produced by decode for the instruction entering execute |
| fwd_a | input | 2 | Operand A select: 0 register file, 1 execute, 2 memory, 3 write-back |
| fwd_b | input | 2 | Operand B select, same encoding |
| pc_we | output | 1 | PC write enable, low during a stall |
| ir_we | output | 1 | Instruction-register write enable, low during a stall |
| bubble | output | 1 | High when a stall is in effect and an empty slot goes into execute |
| ex_ctrl | output | 8 | Execute-stage control register |
| ex_load | output | 1 | Memory-read flag of the instruction in execute |

## Verification
The assertions assume that the cleared-bit mask covers the memory-read bit. Elaboration enforces this, and it is what makes a stall end after one cycle. They do not assume that the operand selects match the pipeline contents. The bench still drives those selects as a free sweep over every pairing of load/no-load with all sixteen select pairs, and it keeps the selects unchanged across the cycle after a stall. The bench keeps its own model of the execute control word and computes each expected stall and register value from that model. It varies the decode word, so some non-stalled words carry a load and the next step starts with a load in execute.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
   localparam int unsigned FWD_W = 2;

   typedef enum logic [FWD_W-1:0] {
      FWD_RF  = 2'd0,
      FWD_EX  = 2'd1,
      FWD_MEM = 2'd2,
      FWD_WB  = 2'd3
   } fwd_sel_e;
endpackage

// File: rtl/ldu_detect.sv
module ldu_detect
   import ldu_pkg::*;
(
   input  logic             load_in_ex,
   input  logic [FWD_W-1:0] sel_a,
   input  logic [FWD_W-1:0] sel_b,
   output logic             hold
);
   logic a_needs_ex;
   logic b_needs_ex;

   always_comb begin
      a_needs_ex = (sel_a == FWD_EX);
      b_needs_ex = (sel_b == FWD_EX);
      hold       = load_in_ex & (a_needs_ex | b_needs_ex);
   end
endmodule

// File: rtl/ldu_ctrl_gate.sv
module ldu_ctrl_gate #(
   parameter int unsigned     CTRL_W     = 8,
   parameter logic [CTRL_W-1:0] CLEAR_MASK = '1
) (
   input  logic              squash,
   input  logic [CTRL_W-1:0] ctrl_in,
   output logic [CTRL_W-1:0] ctrl_out
);
   for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
      if (CLEAR_MASK[i]) begin : g_clr
         assign ctrl_out[i] = ctrl_in[i] & ~squash;
      end else begin : g_pass
         assign ctrl_out[i] = ctrl_in[i];
      end
   end
endmodule

// File: rtl/ldu_ex_ctrl_reg.sv
module ldu_ex_ctrl_reg #(
   parameter int unsigned CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] d,
   output logic [CTRL_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/ld_use_stall_unit.sv
module ld_use_stall_unit
   import ldu_pkg::*;
#(
   parameter int unsigned       CTRL_W     = 8,
   parameter int unsigned       MEMRD_BIT  = 1,
   parameter logic [CTRL_W-1:0] CLEAR_MASK = 8'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] id_ctrl,
   input  logic [1:0]        fwd_a,
   input  logic [1:0]        fwd_b,
   output logic              pc_we,
   output logic              ir_we,
   output logic              bubble,
   output logic [CTRL_W-1:0] ex_ctrl,
   output logic              ex_load
);
   localparam logic [CTRL_W-1:0] KEEP_MASK = ~CLEAR_MASK;

   if (MEMRD_BIT >= CTRL_W) begin : g_bad_bit
      $error("MEMRD_BIT lies outside the control word");
   end
   if (!CLEAR_MASK[MEMRD_BIT]) begin : g_bad_mask
      $error("CLEAR_MASK must cover the memory-read bit");
   end
   if (FWD_W != 2) begin : g_bad_fwd
      $error("forwarding select width must be 2");
   end

   logic              hold;
   logic [CTRL_W-1:0] next_ctrl;

   assign ex_load = ex_ctrl[MEMRD_BIT];

   ldu_detect u_detect (
      .load_in_ex (ex_load),
      .sel_a      (fwd_a),
      .sel_b      (fwd_b),
      .hold       (hold)
   );

   ldu_ctrl_gate #(.CTRL_W(CTRL_W), .CLEAR_MASK(CLEAR_MASK)) u_gate (
      .squash   (hold),
      .ctrl_in  (id_ctrl),
      .ctrl_out (next_ctrl)
   );

   ldu_ex_ctrl_reg #(.CTRL_W(CTRL_W)) u_exreg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (next_ctrl),
      .q     (ex_ctrl)
   );

   assign bubble = hold;
   assign pc_we  = ~hold;
   assign ir_we  = ~hold;

   AST_ONE_CYCLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> !bubble); // R6
   AST_LOAD_LEAVES_EX: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> !ex_load); // R6
   AST_BUBBLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> ((ex_ctrl & CLEAR_MASK) == '0)); // R4
   AST_KEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> ((ex_ctrl & KEEP_MASK) == ($past(id_ctrl) & KEEP_MASK))); // R8
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !bubble |=> (ex_ctrl == $past(id_ctrl))); // R5
   AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_load |-> (!bubble && pc_we && ir_we)); // R2
endmodule

// File: tb/tb_ld_use_stall_unit.sv
module tb_ld_use_stall_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] id_ctrl = '0;
   logic [1:0] fwd_a = '0;
   logic [1:0] fwd_b = '0;
   logic       pc_we, ir_we, bubble, ex_load;
   logic [7:0] ex_ctrl;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] model_ex;

   localparam logic [7:0] CLR = 8'h1F;

   always #10 clk = ~clk;

   ld_use_stall_unit dut (
      .clk(clk), .rst_n(rst_n), .id_ctrl(id_ctrl),
      .fwd_a(fwd_a), .fwd_b(fwd_b),
      .pc_we(pc_we), .ir_we(ir_we), .bubble(bubble),
      .ex_ctrl(ex_ctrl), .ex_load(ex_load)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_comb(input string req);
      logic st;
      st = model_ex[1] && (fwd_a == 2'd1 || fwd_b == 2'd1);
      chk(req, {29'd0, bubble, pc_we, ir_we}, {29'd0, st, ~st, ~st});
      chk("R9", {31'd0, ex_load}, {31'd0, model_ex[1]});
   endtask

   task automatic step_and_check(input string req);
      logic st;
      st = model_ex[1] && (fwd_a == 2'd1 || fwd_b == 2'd1);
      model_ex = st ? (id_ctrl & ~CLR) : id_ctrl;
      @(posedge clk);
      @(negedge clk);
      chk(req, {24'd0, ex_ctrl}, {24'd0, model_ex});
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      model_ex = '0;
      @(negedge clk);
      @(negedge clk);
      // R7: state under reset
      chk("R7", {24'd0, ex_ctrl}, 32'd0);
      chk("R7", {29'd0, ex_load, pc_we, ir_we}, {29'd0, 1'b0, 1'b1, 1'b1});
      chk("R7", {31'd0, bubble}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep: load/no-load in execute times all select pairs
      for (int ld = 0; ld < 2; ld++) begin
         for (int fa = 0; fa < 4; fa++) begin
            for (int fb = 0; fb < 4; fb++) begin
               id_ctrl = ld[0] ? 8'h03 : 8'h01;
               fwd_a = 2'd0;
               fwd_b = 2'd0;
               #2;
               chk_comb("R2");
               step_and_check("R5");
               fwd_a = fa[1:0];
               fwd_b = fb[1:0];
               id_ctrl = 8'(fa * 53 + fb * 29 + ld * 7) | 8'hE0;
               #2;
               if (ld == 0)                 chk_comb("R2");
               else if (fa == 1 || fb == 1) chk_comb("R1");
               else                         chk_comb("R3");
               if (bubble) begin
                  step_and_check("R4");
                  chk("R8", {29'd0, ex_ctrl[7:5]}, {29'd0, 3'b111});
                  // selects held at 1: load has left execute
                  #2;
                  chk_comb("R6");
                  chk("R6", {31'd0, bubble}, 32'd0);
                  fwd_a = 2'd2;
                  step_and_check("R5");
               end else begin
                  step_and_check("R5");
               end
            end
         end
      end

      // Directed: load, dependent consumer via code 1, then code 2
      id_ctrl = 8'h03; fwd_a = 2'd0; fwd_b = 2'd0;
      step_and_check("R5");
      id_ctrl = 8'hFF; fwd_b = 2'd1;
      #2;
      chk_comb("R1");
      step_and_check("R4");
      chk("R8", {24'd0, ex_ctrl}, 32'hE0);
      fwd_b = 2'd2;
      #2;
      chk_comb("R3");
      step_and_check("R5");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule